// File: doc/BRIEF.md
# Sequential Byte Multiplier and Divider

This unit performs unsigned multiplication or division of two bytes held in an accumulator-style register pair, called A and B here. A single-cycle start pulse launches the operation and selects it through `op`. The unit then walks through the operands two bits per clock. Shift-and-add forms the product, and restoring subtraction forms the quotient. After a latency that does not depend on the operand values, it writes the results back onto its A and B outputs and pulses `done`.

Both operations split their results over the pair in the same way. A multiply places the high byte of the 16-bit product on B and the low byte on A. A divide places the quotient on A and the remainder on B. The carry output is cleared whenever an operation finishes. The overflow output reports either a product that does not fit in one byte or an attempt to divide by zero. The surrounding control logic feeds the current register contents into `a_in`/`b_in` and copies `a_out`/`b_out` back when `done` is seen.

Top module: `mdu8_seq`

## Requirements
- R1: While `rst_n` is low, and until the first operation completes, `a_out`, `b_out`, `ov`, `cy` and `done` are all 0.
- R2: With `op` = 0 (multiply) on an accepted start, the unit completes with `{b_out, a_out}` equal to the unsigned 16-bit product of `a_in` and `b_in`.
- R3: With `op` = 1 (divide) and a nonzero `b_in` on an accepted start, `a_out` becomes the unsigned quotient `a_in / b_in` and `b_out` becomes the remainder. For example, 25 divided by 6 gives 4 remainder 1.
- R4: A start accepted at a rising edge makes `done` high for exactly one cycle, in the cycle that follows the third rising edge after it. Every operand value and both operations give this same latency of four cycles.
- R5: A start is accepted only when no operation is in progress. Starts, operands and `op` values presented at the three edges after an accepted start have no effect. A start presented in the cycle where `done` is high is accepted.
- R6: `cy` is 0 in every cycle in which `done` is high.
- R7: On completion of a multiply, `ov` is 1 exactly when the product exceeds 255, that is, when `b_out` is nonzero.
- R8: On completion of a divide, `ov` is 1 exactly when the divisor was 0. After a divide by zero, `a_out` and `b_out` hold constant values until the next completion.
- R9: `a_out`, `b_out` and `ov` change only at the edge that raises `done`. They hold their values in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch request, sampled at the rising edge |
| op | input | 1 | Operation select: 0 multiply, 1 divide |
| a_in | input | 8 | Current A register value (multiplicand or dividend) |
| b_in | input | 8 | Current B register value (multiplier or divisor) |
| a_out | output | 8 | Result for A: product low byte or quotient |
| b_out | output | 8 | Result for B: product high byte or remainder |
| ov | output | 1 | Overflow flag: product above 255, or divisor zero |
| cy | output | 1 | Carry flag, cleared on completion |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench targets the extremes of both paths. It runs 255 times 255 and products that just reach or stay below 256, where an adder that lost its carry into the high byte would corrupt B or misreport overflow. It also runs divides by 1, by 255, by a divisor larger than the dividend, and by zero, where a wrong trial subtraction would give an off-by-one quotient or a missing overflow flag. Starts are held high across a running operation and re-asserted in the `done` cycle. An engine that re-latched operands or mishandled the idle boundary would then shift the `done` pulse or mix two operations' results. Randomised traffic is compared cycle by cycle against an arithmetic model, so a result that moved outside the completion edge would also be caught.

// File: rtl/mdu8_pkg.sv
`timescale 1ns/1ps
package mdu8_pkg;

    typedef enum logic {
        MDU_OP_MUL = 1'b0,
        MDU_OP_DIV = 1'b1
    } mdu_op_e;

endpackage

// File: rtl/mdu_mul_step.sv
`timescale 1ns/1ps
// One shift-and-add step: conditionally add the multiplicand into the
// upper half, then shift the {carry, upper, lower} pair right one place.
module mdu_mul_step #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] hi_i,
    input  logic [WIDTH-1:0] lo_i,
    input  logic [WIDTH-1:0] mcand_i,
    output logic [WIDTH-1:0] hi_o,
    output logic [WIDTH-1:0] lo_o
);
    logic [WIDTH:0] sum;

    always_comb begin
        sum  = {1'b0, hi_i} + (lo_i[0] ? {1'b0, mcand_i} : '0);
        hi_o = sum[WIDTH:1];
        lo_o = {sum[0], lo_i[WIDTH-1:1]};
    end
endmodule

// File: rtl/mdu_div_step.sv
`timescale 1ns/1ps
// One restoring-division step: bring the next dividend bit into the
// partial remainder, subtract the divisor when it fits, shift in the quotient bit.
module mdu_div_step #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] rem_i,
    input  logic [WIDTH-1:0] work_i,
    input  logic [WIDTH-1:0] divisor_i,
    output logic [WIDTH-1:0] rem_o,
    output logic [WIDTH-1:0] work_o
);
    logic [WIDTH:0]   trial;
    logic [WIDTH-1:0] diff;
    logic             fits;

    always_comb begin
        trial  = {rem_i, work_i[WIDTH-1]};
        fits   = (trial >= {1'b0, divisor_i});
        diff   = trial[WIDTH-1:0] - divisor_i;
        rem_o  = fits ? diff : trial[WIDTH-1:0];
        work_o = {work_i[WIDTH-2:0], fits};
    end
endmodule

// File: rtl/mdu8_seq.sv
`timescale 1ns/1ps
module mdu8_seq #(
    parameter int WIDTH          = 8,
    parameter int BITS_PER_CYCLE = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             op,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] a_out,
    output logic [WIDTH-1:0] b_out,
    output logic             ov,
    output logic             cy,
    output logic             done
);
    import mdu8_pkg::*;

    localparam int STEPS = WIDTH / BITS_PER_CYCLE;
    localparam int CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1;

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        mdu_op_e          op;
        logic [WIDTH-1:0] hi;     // product high / partial remainder
        logic [WIDTH-1:0] lo;     // multiplier-product low / dividend-quotient
        logic [WIDTH-1:0] opnd;   // multiplicand or divisor
        logic [WIDTH-1:0] a_res;
        logic [WIDTH-1:0] b_res;
        logic             ov;
        logic             cy;
        logic             done;
    } mdu_state_t;

    mdu_state_t state_d, state_q;

    logic             accept;
    logic             last;
    mdu_op_e          cur_op;
    logic [WIDTH-1:0] src_hi, src_lo, src_opnd;
    logic [WIDTH-1:0] step_hi, step_lo;
    logic             busy;

    logic [WIDTH-1:0] mul_hi   [BITS_PER_CYCLE+1];
    logic [WIDTH-1:0] mul_lo   [BITS_PER_CYCLE+1];
    logic [WIDTH-1:0] div_rem  [BITS_PER_CYCLE+1];
    logic [WIDTH-1:0] div_work [BITS_PER_CYCLE+1];

    // Operand source: fresh inputs on the accepting edge, registers afterwards.
    always_comb begin
        accept   = start && !state_q.busy;
        cur_op   = accept ? mdu_op_e'(op) : state_q.op;
        src_hi   = accept ? '0   : state_q.hi;
        src_lo   = accept ? a_in : state_q.lo;
        src_opnd = accept ? b_in : state_q.opnd;
        if (accept) last = (STEPS == 1);
        else        last = (state_q.cnt == CNT_W'(STEPS - 1));
    end

    assign mul_hi[0]   = src_hi;
    assign mul_lo[0]   = src_lo;
    assign div_rem[0]  = src_hi;
    assign div_work[0] = src_lo;

    for (genvar g = 0; g < BITS_PER_CYCLE; g++) begin : g_step
        mdu_mul_step #(.WIDTH(WIDTH)) u_mul (
            .hi_i    (mul_hi[g]),
            .lo_i    (mul_lo[g]),
            .mcand_i (src_opnd),
            .hi_o    (mul_hi[g+1]),
            .lo_o    (mul_lo[g+1])
        );
        mdu_div_step #(.WIDTH(WIDTH)) u_div (
            .rem_i     (div_rem[g]),
            .work_i    (div_work[g]),
            .divisor_i (src_opnd),
            .rem_o     (div_rem[g+1]),
            .work_o    (div_work[g+1])
        );
    end

    always_comb begin
        if (cur_op == MDU_OP_MUL) begin
            step_hi = mul_hi[BITS_PER_CYCLE];
            step_lo = mul_lo[BITS_PER_CYCLE];
        end else begin
            step_hi = div_rem[BITS_PER_CYCLE];
            step_lo = div_work[BITS_PER_CYCLE];
        end
    end

    always_comb begin
        state_d      = state_q;
        state_d.done = 1'b0;
        if (accept || state_q.busy) begin
            state_d.op   = cur_op;
            state_d.opnd = src_opnd;
            state_d.hi   = step_hi;
            state_d.lo   = step_lo;
            state_d.busy = 1'b1;
            state_d.cnt  = accept ? CNT_W'(1) : state_q.cnt + CNT_W'(1);
            if (last) begin
                state_d.busy  = 1'b0;
                state_d.cnt   = '0;
                state_d.done  = 1'b1;
                state_d.cy    = 1'b0;
                // Both operations place their results the same way:
                // upper/remainder on B, lower/quotient on A.
                state_d.a_res = step_lo;
                state_d.b_res = step_hi;
                if (cur_op == MDU_OP_MUL) state_d.ov = (step_hi != '0);
                else                      state_d.ov = (src_opnd == '0);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign busy  = state_q.busy;
    assign a_out = state_q.a_res;
    assign b_out = state_q.b_res;
    assign ov    = state_q.ov;
    assign cy    = state_q.cy;
    assign done  = state_q.done;
endmodule

// File: rtl/mdu8_seq_chk.sv
`timescale 1ns/1ps
module mdu8_seq_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             op,
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] b_in,
    input logic             busy,
    input logic [WIDTH-1:0] a_out,
    input logic [WIDTH-1:0] b_out,
    input logic             ov,
    input logic             cy,
    input logic             done
);
    logic               op_l;
    logic [WIDTH-1:0]   a_l, b_l;
    logic [2*WIDTH-1:0] prod_l;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_l   <= 1'b0;
            a_l    <= '0;
            b_l    <= '0;
            prod_l <= '0;
        end else if (start && !busy) begin
            op_l   <= op;
            a_l    <= a_in;
            b_l    <= b_in;
            prod_l <= (2*WIDTH)'(a_in) * (2*WIDTH)'(b_in);
        end
    end

    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |-> ##4 done); // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R4
    AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !done)); // R5
    AST_CARRY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !cy); // R6
    AST_MUL_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !op_l) |-> ({b_out, a_out} == prod_l)); // R2
    AST_DIV_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_l && (b_l != '0)) |-> (a_out == a_l / b_l && b_out == a_l % b_l)); // R3
    AST_MUL_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !op_l) |-> (ov == (b_out != '0))); // R7
    AST_DIV_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_l) |-> (ov == (b_l == '0))); // R8
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(a_out) && $stable(b_out) && $stable(ov))); // R9
endmodule

bind mdu8_seq mdu8_seq_chk #(.WIDTH(WIDTH)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .op    (op),
    .a_in  (a_in),
    .b_in  (b_in),
    .busy  (busy),
    .a_out (a_out),
    .b_out (b_out),
    .ov    (ov),
    .cy    (cy),
    .done  (done)
);

// File: tb/mdu8_seq_test.sv
`timescale 1ns/1ps
module mdu8_seq_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       op = 1'b0;
    logic [7:0] a_in = 8'h00;
    logic [7:0] b_in = 8'h00;
    logic [7:0] a_out, b_out;
    logic       ov, cy, done;

    always #2 clk = ~clk;   // 250 MHz

    mdu8_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .a_in(a_in), .b_in(b_in), .a_out(a_out), .b_out(b_out),
        .ov(ov), .cy(cy), .done(done)
    );

    int errors = 0;
    int checks = 0;
    bit running = 0;

    // Behavioural reference model
    int m_left = 0;
    bit m_op = 0;
    int m_a = 0, m_b = 0;
    int e_a = 0, e_b = 0;
    bit e_ov = 0, e_done = 0, e_known = 1, e_last_div = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_left = 0; e_a = 0; e_b = 0; e_ov = 0; e_done = 0; e_known = 1;
        end else begin
            e_done = 0;
            if (m_left > 0) begin
                m_left = m_left - 1;
                if (m_left == 0) begin
                    e_done = 1;
                    e_last_div = m_op;
                    if (!m_op) begin
                        e_a = (m_a * m_b) % 256;
                        e_b = (m_a * m_b) / 256;
                        e_ov = (m_a * m_b) > 255;
                        e_known = 1;
                    end else if (m_b == 0) begin
                        e_ov = 1;
                        e_known = 0;
                    end else begin
                        e_a = m_a / m_b;
                        e_b = m_a % m_b;
                        e_ov = 0;
                        e_known = 1;
                    end
                end
            end else if (start) begin
                m_left = 3;
                m_op = op;
                m_a = int'(a_in);
                m_b = int'(b_in);
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Per-cycle comparison, away from the active edge
    logic [7:0] held_a = 8'h00, held_b = 8'h00;
    always @(negedge clk) begin
        if (running) begin
            check(done == e_done, "R4", "done", int'(done), int'(e_done));
            check(ov == e_ov, e_last_div ? "R8" : "R7", "ov", int'(ov), int'(e_ov));
            if (done) check(cy == 1'b0, "R6", "cy", int'(cy), 0);
            if (e_known) begin
                check(int'(a_out) == e_a, done ? (e_last_div ? "R3" : "R2") : "R9",
                      "a_out", int'(a_out), e_a);
                check(int'(b_out) == e_b, done ? (e_last_div ? "R3" : "R2") : "R9",
                      "b_out", int'(b_out), e_b);
            end else if (!done) begin
                check(a_out == held_a && b_out == held_b, "R8", "div0 results stable",
                      int'({a_out, b_out}), int'({held_a, held_b}));
            end
            held_a = a_out;
            held_b = b_out;
        end
    end

    // Launch one op; returns in the cycle where done is expected high
    task automatic run_op(input bit o, input logic [7:0] a, input logic [7:0] b);
        start = 1'b1; op = o; a_in = a; b_in = b;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R4 watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(a_out == 0 && b_out == 0, "R1", "reset results", int'({a_out, b_out}), 0);
        check(!ov && !cy && !done, "R1", "reset flags", int'({ov, cy, done}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        running = 1;

        // R3: worked divide example
        run_op(1'b1, 8'd25, 8'd6);
        check(a_out == 8'd4 && b_out == 8'd1, "R3", "25/6", int'({a_out, b_out}), 16'h0401);
        // R2, R7: largest product
        run_op(1'b0, 8'hFF, 8'hFF);
        check({b_out, a_out} == 16'hFE01 && ov, "R7", "255*255", int'({b_out, a_out}), 16'hFE01);
        run_op(1'b0, 8'd15, 8'd17);     // 255, no overflow (R7)
        run_op(1'b0, 8'd16, 8'd16);     // 256, overflow (R7)
        run_op(1'b0, 8'd0, 8'd200);
        run_op(1'b1, 8'd200, 8'd1);
        run_op(1'b1, 8'd255, 8'd255);
        run_op(1'b1, 8'd7, 8'd9);       // quotient 0
        // R8: divide by zero sets ov
        run_op(1'b1, 8'd77, 8'd0);
        check(ov == 1'b1, "R8", "div by zero ov", int'(ov), 1);
        repeat (5) @(negedge clk);
        run_op(1'b1, 8'd100, 8'd7);     // ov cleared again (R8)

        // R5: start held through a running op with changing operands
        start = 1'b1; op = 1'b0; a_in = 8'd12; b_in = 8'd11;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            op = i[0]; a_in = 8'(i * 37 + 5); b_in = 8'(i * 13);
        end
        start = 1'b0;
        repeat (6) @(negedge clk);

        // Randomised traffic, start density about one in three (R5, R9)
        for (int i = 0; i < 600; i++) begin
            start = ($urandom_range(0, 2) == 0);
            op    = 1'($urandom_range(0, 1));
            a_in  = 8'($urandom_range(0, 255));
            b_in  = ($urandom_range(0, 9) == 0) ? 8'h00 : 8'($urandom_range(0, 255));
            @(negedge clk);
        end
        start = 1'b0;
        repeat (6) @(negedge clk);
        running = 0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule